// File: doc/BRIEF.md
# Display Interrupt Status Register

This block holds the interrupt control and status word of a display controller. It sits behind a simple register port: one write strobe, one address and one write word. The read word is a combinational view of the addressed location. Event generators elsewhere in the controller send single-cycle pulses for frame completion, field completion, pixel FIFO underrun and a bus error seen by the display DMA master. A separate control register supplies a global interrupt enable and a select that chooses frame or field granularity for completion. Each pulse is caught in a sticky status bit, and software clears that bit by writing 1 to it.

There are two completion status bits. The raw bit records every completion. The internal bit records a completion only when the completion enable is on. Underrun has its own enable. Bus error is always qualified. The block drives one registered, level-sensitive interrupt request. That request combines the qualified status bits with the global enable.

Top module: `disp_irq_regs`

## Requirements
- R1: During and directly after reset, the register reads 0x0000_0000 and `irq` is 0.
- R2: A completion event sets bit 31 (raw completion status) on the next clock edge, whatever the value of enable bit 0.
- R3: A completion event sets bit 30 (internal completion status) only when enable bit 0 is 1 in the same cycle.
- R4: With `field_sel` = 0, only `frame_done` is a completion event. With `field_sel` = 1, only `field_done` is. The other pulse has no effect on bits 31 and 30.
- R5: An `underrun` pulse sets bit 29, and a `bus_err` pulse sets bit 28, on the next edge.
- R6: A write to the register with 1 in any of bits 31..28 clears that status bit. A write with 0 in one of those bits leaves it unchanged, and a write never sets a status bit.
- R7: If a clearing write and a set event reach the same status bit in the same cycle, the bit stays 1.
- R8: Bit 1 (underrun enable) and bit 0 (completion enable) take the written value and read back as written. Changing them leaves status bits unchanged. Bits 27..2 read 0 and ignore writes.
- R9: `irq` is registered. One edge after a cycle in which `disp_int_en` is 1 and at least one of these holds, it reads 1; otherwise it reads 0. The terms are: (bit 31 or bit 30) with bit 0; bit 29 with bit 1; bit 28.
- R10: Bus error status raises `irq` whenever `disp_int_en` is 1, with both enable bits at 0.
- R11: The register answers only at address `REG_OFFSET` (default 0x0C). Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write word |
| reg_rdata | output | DATA_W | Read word for `reg_addr` (combinational) |
| disp_int_en | input | 1 | Global display interrupt enable from the control register |
| field_sel | input | 1 | 0: completion per frame, 1: completion per field |
| frame_done | input | 1 | Pulse at end of a frame |
| field_done | input | 1 | Pulse at end of a field |
| underrun | input | 1 | Pulse on pixel FIFO underrun |
| bus_err | input | 1 | Pulse on a DMA bus error response |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 32-bit word and the register at 0x0C. That leaves 0x08 one word below as a neighbouring address where a write must change nothing and a read must return zero. With the full 32-bit word, all-ones writes reach the reserved middle bits alongside the status and enable fields. This shows whether reserved bits stay at zero and whether writes can only clear status bits.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  // status vector index; register bit = STAT_LSB + index
  localparam int unsigned ST_BUS   = 0;
  localparam int unsigned ST_UR    = 1;
  localparam int unsigned ST_INT   = 2;
  localparam int unsigned ST_RAW   = 3;
  localparam int unsigned NUM_STAT = 4;
  localparam int unsigned STAT_LSB = 28;

  // enable field, starting at register bit 0
  localparam int unsigned EN_CMP   = 0;
  localparam int unsigned EN_UR    = 1;
  localparam int unsigned NUM_EN   = 2;

  localparam int unsigned MIN_DATA_W = STAT_LSB + NUM_STAT;

  typedef enum logic {
    CMP_FRAME = 1'b0,
    CMP_FIELD = 1'b1
  } cmp_gran_e;

endpackage

// File: rtl/disp_irq_evt_sel.sv
module disp_irq_evt_sel
  import disp_irq_pkg::*;
(
  input  logic field_sel,
  input  logic frame_done,
  input  logic field_done,
  output logic cmp_evt
);

  cmp_gran_e gran;

  always_comb begin
    gran = cmp_gran_e'(field_sel);
    unique case (gran)
      CMP_FIELD: cmp_evt = field_done;
      default:   cmp_evt = frame_done;
    endcase
  end

endmodule

// File: rtl/disp_irq_stat_cell.sv
module disp_irq_stat_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/disp_irq_req.sv
module disp_irq_req
  import disp_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_en,
  input  logic [NUM_STAT-1:0] stat,
  input  logic [NUM_EN-1:0]   en,
  output logic                irq
);

  logic [NUM_STAT-1:0] qual;
  logic                any_qual;

  always_comb begin
    qual         = '0;
    qual[ST_RAW] = stat[ST_RAW] & en[EN_CMP];
    qual[ST_INT] = stat[ST_INT] & en[EN_CMP];
    qual[ST_UR]  = stat[ST_UR]  & en[EN_UR];
    qual[ST_BUS] = stat[ST_BUS];
    any_qual     = |qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= gen_en & any_qual;
  end

endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
  import disp_irq_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 8,
  parameter int unsigned     DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              disp_int_en,
  input  logic              field_sel,
  input  logic              frame_done,
  input  logic              field_done,
  input  logic              underrun,
  input  logic              bus_err,
  output logic              irq
);

  localparam int unsigned STAT_MSB = STAT_LSB + NUM_STAT - 1;

  // bits software may touch; everything else is reserved
  localparam logic [DATA_W-1:0] WR_MASK =
    (((DATA_W)'(1) << NUM_STAT) - (DATA_W)'(1)) << STAT_LSB |
    (((DATA_W)'(1) << NUM_EN)   - (DATA_W)'(1));

  logic                hit;
  logic                wr_hit;
  logic [DATA_W-1:0]   wkeep;
  logic                cmp_evt;
  logic [NUM_EN-1:0]   en_q;
  logic [NUM_STAT-1:0] set_req;
  logic [NUM_STAT-1:0] clr_req;
  logic [NUM_STAT-1:0] stat_q;

  assign hit    = (reg_addr == REG_OFFSET);
  assign wr_hit = reg_wr & hit;
  assign wkeep  = reg_wdata & WR_MASK;

  disp_irq_evt_sel u_sel (
    .field_sel  (field_sel),
    .frame_done (frame_done),
    .field_done (field_done),
    .cmp_evt    (cmp_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= wkeep[NUM_EN-1:0];
  end

  always_comb begin
    set_req         = '0;
    set_req[ST_RAW] = cmp_evt;
    set_req[ST_INT] = cmp_evt & en_q[EN_CMP];
    set_req[ST_UR]  = underrun;
    set_req[ST_BUS] = bus_err;
  end

  for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
    assign clr_req[i] = wr_hit & wkeep[STAT_LSB + i];
    disp_irq_stat_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_req[i]),
      .clr_i (clr_req[i]),
      .q_o   (stat_q[i])
    );
  end

  disp_irq_req u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .gen_en (disp_int_en),
    .stat   (stat_q),
    .en     (en_q),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      reg_rdata[STAT_MSB:STAT_LSB] = stat_q;
      reg_rdata[NUM_EN-1:0]        = en_q;
    end
  end

endmodule

// File: rtl/disp_irq_regs_chk.sv
module disp_irq_regs_chk
  import disp_irq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                disp_int_en,
  input logic                bus_err,
  input logic                wr_hit,
  input logic [NUM_STAT-1:0] clr_req,
  input logic                cmp_evt,
  input logic [NUM_EN-1:0]   en_q,
  input logic [NUM_STAT-1:0] stat_q,
  input logic                irq
);

  assert_raw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> stat_q[ST_RAW]);

  assert_int_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_INT]) |-> $past(cmp_evt && en_q[EN_CMP]));

  assert_bus_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> stat_q[ST_BUS]);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && clr_req[ST_BUS] && bus_err) |=> stat_q[ST_BUS]);

  assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_int_en |=> !irq);

  assert_bus_always_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_int_en && stat_q[ST_BUS]) |=> irq);

endmodule

bind disp_irq_regs disp_irq_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_int_en (disp_int_en),
  .bus_err     (bus_err),
  .wr_hit      (wr_hit),
  .clr_req     (clr_req),
  .cmp_evt     (cmp_evt),
  .en_q        (en_q),
  .stat_q      (stat_q),
  .irq         (irq)
);

// File: tb/disp_irq_regs_test.sv
module disp_irq_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam logic [7:0] OFS = 8'h0C;

  typedef struct packed {
    logic        wr;
    logic [31:0] wdata;
    logic        gen;
    logic        fs;
    logic        fr;
    logic        fd;
    logic        ur;
    logic        be;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  // each row: stimulus for one cycle, one idle cycle, then check
  localparam vec_t VECS [0:16] = '{
    '{1'b1, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0003, 1'b0}, // R8
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hC000_0003, 1'b0}, // R2 R3 R9
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hC000_0003, 1'b1}, // R9
    '{1'b1, 32'h8000_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_0003, 1'b1}, // R6 R9
    '{1'b1, 32'h4000_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0003, 1'b0}, // R6
    '{1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0}, // R8
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 1'b0}, // R2 R3 R4
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0}, // R4
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 1'b0}, // R4
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hA000_0000, 1'b0}, // R5
    '{1'b1, 32'h0000_0002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA000_0002, 1'b1}, // R8 R9
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hB000_0002, 1'b1}, // R5
    '{1'b1, 32'h2000_0002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h9000_0002, 1'b1}, // R6 R10
    '{1'b1, 32'h1000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0}, // R6
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h9000_0000, 1'b0}, // R9
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h9000_0000, 1'b1}, // R10
    '{1'b1, 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0}  // R6 R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = OFS;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        disp_int_en = 1'b0;
  logic        field_sel = 1'b0;
  logic        frame_done = 1'b0;
  logic        field_done = 1'b0;
  logic        underrun = 1'b0;
  logic        bus_err = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_irq_regs uut (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .disp_int_en (disp_int_en),
    .field_sel (field_sel), .frame_done (frame_done), .field_done (field_done),
    .underrun (underrun), .bus_err (bus_err), .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_pulses();
    reg_wr = 1'b0; frame_done = 1'b0; field_done = 1'b0;
    underrun = 1'b0; bus_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 17; i++) begin
      reg_wr = VECS[i].wr; reg_wdata = VECS[i].wdata;
      disp_int_en = VECS[i].gen; field_sel = VECS[i].fs;
      frame_done = VECS[i].fr; field_done = VECS[i].fd;
      underrun = VECS[i].ur; bus_err = VECS[i].be;
      @(negedge clk);
      idle_pulses();
      @(negedge clk);
      chk($sformatf("R2-R10 vec %0d rdata", i), reg_rdata, VECS[i].exp_rd);
      chk($sformatf("R9 vec %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
    end

    // R9: irq lags the status bit by one edge
    disp_int_en = 1'b1;
    reg_wr = 1'b1; reg_wdata = 32'h0000_0002;
    @(negedge clk);
    idle_pulses(); underrun = 1'b1;
    @(negedge clk);
    idle_pulses();
    chk("R9 status before irq", reg_rdata, 32'h2000_0002);
    chk("R9 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq one edge later", {31'b0, irq}, 32'h1);

    // R7: clear and set on the same bit in one cycle
    reg_wr = 1'b1; reg_wdata = 32'h2000_0002; underrun = 1'b1;
    @(negedge clk);
    idle_pulses();
    chk("R7 set wins over clear", reg_rdata, 32'h2000_0002);
    reg_wr = 1'b1; reg_wdata = 32'h2000_0000;
    @(negedge clk);
    idle_pulses();
    chk("R7 later clear works", reg_rdata, 32'h0);

    // R11: other addresses neither read nor write the register
    bus_err = 1'b1;
    @(negedge clk);
    idle_pulses();
    reg_addr = 8'h08; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    idle_pulses();
    chk("R11 foreign address reads zero", reg_rdata, 32'h0);
    reg_addr = OFS;
    #1;
    chk("R11 foreign write ignored", reg_rdata, 32'h1000_0000);
    @(negedge clk);
    chk("R10 bus error with enables off", {31'b0, irq}, 32'h1);

    // R1: reset in mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset rdata", reg_rdata, 32'h0);
    chk("R1 mid-run reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule